// File: doc/BRIEF.md
# Phase Lock Detector with Lock Mask

This block watches two rising-edge streams: a reference clock and the motor's FG feedback. Both are already synchronous to the system clock. For each pair of edges it raises a speed-up pulse when the reference edge comes first, or a slow-down pulse when the FG edge comes first. The pulse lasts from the leading edge to the trailing edge, so its width carries the phase error. An external loop filter integrates these pulses, and in steady state that loop holds the FG frequency equal to the reference frequency.

Every pulse, once closed, gives an error measured in system ticks. A lock qualifier counts consecutive in-window errors and declares raw lock. A programmable mask then holds the lock output low for a set number of ticks. During that time it ignores the out-of-window errors that appear while the loop hunts. A near-speed detector measures both periods in ticks. It requests a reduced current limit of 87.5 % of nominal (7/8) once the motor runs faster than 95 % of the target speed.

The phase detector has three states:
- PD_IDLE leaves on a lone reference edge (start) to PD_UP, or on a lone FG edge (start) to PD_DN.
- PD_UP returns to PD_IDLE on an FG edge (close). If a new reference edge arrives in the same cycle, it restarts PD_UP.
- PD_DN returns to PD_IDLE on a reference edge (close). If a new FG edge arrives in the same cycle, it restarts PD_DN.
- Coincident edges in PD_IDLE close a zero-width error.

The lock sequencer also has three states:
- LK_HUNT counts good errors. When the count completes (raw lock), it goes to LK_MASK, or straight to LK_HOLD when the mask length is zero.
- LK_MASK goes to LK_HOLD when the mask expires.
- LK_HOLD returns to LK_HUNT on any bad error (dropout).

Top module: `plk_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, pump_up, pump_dn, lock_out and cur_scale are all low.
- R2: When a reference rise is seen L>0 cycles before an FG rise (tick held high), pump_up goes high for exactly L cycles and pump_dn stays low.
- R3: When an FG rise is seen L>0 cycles before a reference rise, pump_dn goes high for exactly L cycles and pump_up stays low.
- R4: Rises on both inputs in the same cycle produce no pulse, and pump_up and pump_dn are never high together.
- R5: Raw lock requires LOCK_CNT consecutive closed errors, each of at most win_len ticks (the width in R2/R3, or 0 for R4). An error of win_len+1 restarts the count.
- R6: With mask_len = 0, lock_out rises a few cycles after raw lock and falls a few cycles after the first out-of-window error.
- R7: With mask_len > 0, lock_out stays low for mask_len ticks after raw lock, and out-of-window errors inside that interval are ignored.
- R8: Once lock_out is high, an out-of-window error drops it, and a full new qualification is then needed.
- R9: With nearspd_en high, cur_scale is high when FG span × 95 < reference span × 100. Each span is the larger of the last measured period and the running count since the last rise, in ticks. A 105-cycle FG period against a 100-cycle reference gives high; 106 gives low.
- R10: With nearspd_en low (tie high to use the reduction), cur_scale is low one cycle later.
- R11: If FG stops, cur_scale falls once the running FG count reaches the R9 bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counting enable; all error, mask and period counts advance only on tick cycles |
| ref_in | input | 1 | Reference clock, synchronous to clk |
| fg_in | input | 1 | Motor FG feedback, synchronous to clk |
| nearspd_en | input | 1 | High enables the near-speed current reduction |
| win_len | input | ERR_W | Largest error in ticks that counts as in window |
| mask_len | input | MASK_W | Lock mask length in ticks; 0 disables masking |
| pump_up | output | 1 | Speed-up phase-error pulse |
| pump_dn | output | 1 | Slow-down phase-error pulse |
| lock_out | output | 1 | Masked lock indication |
| cur_scale | output | 1 | High requests a current limit of 7/8 nominal |

## Verification
A wrong phase-detector state appears within one cycle as a pulse that is too long, too short, inverted or spurious, so pulse widths are compared one by one against the edge offsets that were driven. A fault in the qualify count or mask timer only shows at lock_out, one FG period or one mask length later. The bench therefore samples lock after each driven period and across mask boundaries, with deliberate dropouts inside and after the mask. A speed-meter fault shows at cur_scale only after two periods have been measured, so the 105/106-cycle boundary, the enable input and a stopped FG are each checked after that settling time.

// File: rtl/plk_pkg.sv
package plk_pkg;

    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_UP   = 2'd1,
        PD_DN   = 2'd2
    } pd_state_t;

    typedef enum logic [1:0] {
        LK_HUNT = 2'd0,
        LK_MASK = 2'd1,
        LK_HOLD = 2'd2
    } lk_state_t;

endpackage

// File: rtl/plk_phase.sv
module plk_phase
    import plk_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ref_rise,
    input  logic             fg_rise,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             err_valid,
    output logic [ERR_W-1:0] err_ticks
);

    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

    pd_state_t        state, state_nxt;
    logic [ERR_W-1:0] span_cnt;
    logic [ERR_W-1:0] span_inc;
    logic             close;

    // saturating tick count including the current cycle
    assign span_inc = (span_cnt == ERR_MAX) ? span_cnt : span_cnt + ERR_W'(tick);

    always_comb begin
        state_nxt = state;
        close     = 1'b0;
        unique case (state)
            PD_IDLE: begin
                if (ref_rise && fg_rise) begin
                    close = 1'b1;
                end else if (ref_rise) begin
                    state_nxt = PD_UP;
                end else if (fg_rise) begin
                    state_nxt = PD_DN;
                end
            end
            PD_UP: begin
                if (fg_rise) begin
                    close     = 1'b1;
                    state_nxt = ref_rise ? PD_UP : PD_IDLE;
                end
            end
            PD_DN: begin
                if (ref_rise) begin
                    close     = 1'b1;
                    state_nxt = fg_rise ? PD_DN : PD_IDLE;
                end
            end
            default: state_nxt = PD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PD_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            span_cnt  <= '0;
            err_valid <= 1'b0;
            err_ticks <= '0;
        end else begin
            err_valid <= close;
            if (close) begin
                err_ticks <= (state == PD_IDLE) ? '0 : span_inc;
            end
            if (close || state == PD_IDLE) begin
                span_cnt <= '0;
            end else begin
                span_cnt <= span_inc;
            end
        end
    end

    always_comb begin
        pump_up = 1'b0;
        pump_dn = 1'b0;
        unique case (state)
            PD_IDLE: ;
            PD_UP:   pump_up = 1'b1;
            PD_DN:   pump_dn = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/plk_lock.sv
module plk_lock
    import plk_pkg::*;
#(
    parameter int ERR_W    = 8,
    parameter int MASK_W   = 16,
    parameter int LOCK_CNT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              err_valid,
    input  logic [ERR_W-1:0]  err_ticks,
    input  logic [ERR_W-1:0]  win_len,
    input  logic [MASK_W-1:0] mask_len,
    output logic              lock_out
);

    localparam int QW = $clog2(LOCK_CNT + 1);
    localparam logic [QW-1:0] Q_LAST = QW'(LOCK_CNT - 1);

    lk_state_t         state, state_nxt;
    logic [QW-1:0]     qual_cnt;
    logic [MASK_W-1:0] mask_cnt;
    logic              good;
    logic              raw_hit;
    logic              mask_done;
    logic              dropout;

    assign good      = (err_ticks <= win_len);
    assign raw_hit   = err_valid && good && (qual_cnt == Q_LAST);
    assign dropout   = err_valid && !good;
    assign mask_done = tick && ({1'b0, mask_cnt} + 1'b1 == {1'b0, mask_len});

    always_comb begin
        state_nxt = state;
        unique case (state)
            LK_HUNT: begin
                if (raw_hit) begin
                    state_nxt = (mask_len == '0) ? LK_HOLD : LK_MASK;
                end
            end
            LK_MASK: begin
                if (mask_done) begin
                    state_nxt = LK_HOLD;
                end
            end
            LK_HOLD: begin
                if (dropout) begin
                    state_nxt = LK_HUNT;
                end
            end
            default: state_nxt = LK_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LK_HUNT;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_cnt <= '0;
            mask_cnt <= '0;
        end else begin
            if (state != LK_HUNT || raw_hit) begin
                qual_cnt <= '0;
            end else if (err_valid) begin
                qual_cnt <= good ? qual_cnt + 1'b1 : '0;
            end
            if (state != LK_MASK) begin
                mask_cnt <= '0;
            end else if (tick) begin
                mask_cnt <= mask_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        lock_out = 1'b0;
        unique case (state)
            LK_HUNT: lock_out = 1'b0;
            LK_MASK: lock_out = 1'b0;
            LK_HOLD: lock_out = 1'b1;
            default: lock_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/plk_permeter.sv
module plk_permeter #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rise,
    output logic             per_ok,
    output logic [PER_W-1:0] span
);

    localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};

    logic [PER_W-1:0] run_cnt;
    logic [PER_W-1:0] run_inc;
    logic [PER_W-1:0] last_per;
    logic             seen;

    assign run_inc = (run_cnt == PER_MAX) ? run_cnt : run_cnt + PER_W'(tick);
    // a stalled input shows up as a growing span
    assign span    = (run_cnt > last_per) ? run_cnt : last_per;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            last_per <= '0;
            seen     <= 1'b0;
            per_ok   <= 1'b0;
        end else if (rise) begin
            last_per <= run_inc;
            run_cnt  <= '0;
            seen     <= 1'b1;
            per_ok   <= seen;
        end else begin
            run_cnt  <= run_inc;
        end
    end

endmodule

// File: rtl/plk_nearspd.sv
module plk_nearspd #(
    parameter int PER_W   = 16,
    parameter int SPD_NUM = 95,
    parameter int SPD_DEN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ref_rise,
    input  logic fg_rise,
    input  logic enable,
    output logic cur_scale
);

    localparam int NCH  = 2;
    localparam int MULW = PER_W + 8;

    logic [NCH-1:0]   rise_v;
    logic [NCH-1:0]   ok_v;
    logic [PER_W-1:0] span_v [NCH];
    logic [MULW-1:0]  fg_scaled;
    logic [MULW-1:0]  ref_scaled;
    logic             near;

    // channel 0: reference, channel 1: FG
    assign rise_v = {fg_rise, ref_rise};

    for (genvar g = 0; g < NCH; g++) begin : g_meter
        plk_permeter #(
            .PER_W (PER_W)
        ) u_meter (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .rise   (rise_v[g]),
            .per_ok (ok_v[g]),
            .span   (span_v[g])
        );
    end

    assign fg_scaled  = MULW'(span_v[1]) * MULW'(SPD_NUM);
    assign ref_scaled = MULW'(span_v[0]) * MULW'(SPD_DEN);
    assign near       = enable && (&ok_v) && (fg_scaled < ref_scaled);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_scale <= 1'b0;
        end else begin
            cur_scale <= near;
        end
    end

endmodule

// File: rtl/plk_top.sv
module plk_top #(
    parameter int ERR_W    = 8,
    parameter int MASK_W   = 16,
    parameter int LOCK_CNT = 4,
    parameter int PER_W    = 16,
    parameter int SPD_NUM  = 95,
    parameter int SPD_DEN  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ref_in,
    input  logic              fg_in,
    input  logic              nearspd_en,
    input  logic [ERR_W-1:0]  win_len,
    input  logic [MASK_W-1:0] mask_len,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              lock_out,
    output logic              cur_scale
);

    logic             ref_q;
    logic             fg_q;
    logic             ref_rise;
    logic             fg_rise;
    logic             err_valid;
    logic [ERR_W-1:0] err_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            fg_q  <= 1'b0;
        end else begin
            ref_q <= ref_in;
            fg_q  <= fg_in;
        end
    end

    assign ref_rise = ref_in && !ref_q;
    assign fg_rise  = fg_in && !fg_q;

    plk_phase #(
        .ERR_W (ERR_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ref_rise  (ref_rise),
        .fg_rise   (fg_rise),
        .pump_up   (pump_up),
        .pump_dn   (pump_dn),
        .err_valid (err_valid),
        .err_ticks (err_ticks)
    );

    plk_lock #(
        .ERR_W    (ERR_W),
        .MASK_W   (MASK_W),
        .LOCK_CNT (LOCK_CNT)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .err_valid (err_valid),
        .err_ticks (err_ticks),
        .win_len   (win_len),
        .mask_len  (mask_len),
        .lock_out  (lock_out)
    );

    plk_nearspd #(
        .PER_W   (PER_W),
        .SPD_NUM (SPD_NUM),
        .SPD_DEN (SPD_DEN)
    ) u_near (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ref_rise  (ref_rise),
        .fg_rise   (fg_rise),
        .enable    (nearspd_en),
        .cur_scale (cur_scale)
    );

endmodule

// File: rtl/plk_chk.sv
module plk_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_in,
    input logic fg_in,
    input logic nearspd_en,
    input logic pump_up,
    input logic pump_dn,
    input logic cur_scale
);

    // R4
    pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    // R2
    up_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_up) |-> $past(ref_in));

    // R3
    dn_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_dn) |-> $past(fg_in));

    // R10
    scale_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(nearspd_en) |-> !cur_scale);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !pump_up && !pump_dn && !cur_scale);

endmodule

bind plk_top plk_chk u_plk_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_in     (ref_in),
    .fg_in      (fg_in),
    .nearspd_en (nearspd_en),
    .pump_up    (pump_up),
    .pump_dn    (pump_dn),
    .cur_scale  (cur_scale)
);

// File: tb/plk_top_bench.sv
module plk_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ERR_W      = 8;
    localparam int MASK_W     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b1;
    logic              ref_in = 1'b0;
    logic              fg_in = 1'b0;
    logic              nearspd_en = 1'b0;
    logic [ERR_W-1:0]  win_len = 8'd3;
    logic [MASK_W-1:0] mask_len = '0;
    logic              pump_up, pump_dn, lock_out, cur_scale;

    int  n_chk = 0;
    int  n_err = 0;
    int  unexp = 0;
    int  up_w = 0;
    int  dn_w = 0;
    bit  sb_on = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        bit up;
        int width;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    plk_top u_plk_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ref_in     (ref_in),
        .fg_in      (fg_in),
        .nearspd_en (nearspd_en),
        .win_len    (win_len),
        .mask_len   (mask_len),
        .pump_up    (pump_up),
        .pump_dn    (pump_dn),
        .lock_out   (lock_out),
        .cur_scale  (cur_scale)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic sb_pop(input bit up, input int w);
        exp_t e;
        n_chk++;
        if (sb_q.size() == 0) begin
            unexp++;
            n_err++;
            $display("FAIL R4 unexpected %s pulse actual=%0d expected=none",
                     up ? "up" : "dn", w);
        end else begin
            e = sb_q.pop_front();
            if (e.up != up || e.width != w) begin
                n_err++;
                $display("FAIL %s pulse actual=%s/%0d expected=%s/%0d",
                         e.up ? "R2" : "R3", up ? "up" : "dn", w,
                         e.up ? "up" : "dn", e.width);
            end
        end
    endtask

    // monitor: measures each pump pulse and compares with the queue
    always @(negedge clk) begin
        if (rst_n && sb_on) begin
            if (pump_up) up_w++;
            else if (up_w != 0) begin sb_pop(1'b1, up_w); up_w = 0; end
            if (pump_dn) dn_w++;
            else if (dn_w != 0) begin sb_pop(1'b0, dn_w); dn_w = 0; end
        end
    end

    // driver: one period of p cycles with fg lagging ref by lag cycles
    task automatic pair(input int p, input int lag);
        exp_t e;
        if (lag != 0) begin
            e.up    = (lag > 0);
            e.width = (lag > 0) ? lag : -lag;
            sb_q.push_back(e);
        end
        for (int k = 0; k < p; k++) begin
            @(posedge clk);
            #1;
            ref_in = (lag >= 0) ? (k == 0) : (k == -lag);
            fg_in  = (lag >= 0) ? (k == lag) : (k == 0);
        end
    endtask

    task automatic spin(input int pr, input int pf, input int cycles, input bit fg_on);
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            #1;
            ref_in = (c % pr == 0);
            fg_in  = fg_on && (c % pf == 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(pump_up, 1'b0, "R1 pump_up in reset");
        chk(lock_out, 1'b0, "R1 lock in reset");
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(pump_up | pump_dn, 1'b0, "R1 pumps after reset");
        chk(lock_out, 1'b0, "R1 lock after reset");
        chk(cur_scale, 1'b0, "R1 cur_scale after reset");
        sb_on = 1'b1;

        // R5: out-of-window errors never lock
        pair(40, 5); pair(40, 6);
        @(negedge clk); chk(lock_out, 1'b0, "R5 bad errors");
        // R5: three good is not enough
        pair(40, 2); pair(40, -3); pair(40, 3);
        @(negedge clk); chk(lock_out, 1'b0, "R5 three good");
        // R5: win_len+1 restarts the count
        pair(40, 4);
        pair(40, 1); pair(40, 0);
        @(negedge clk); chk(unexp == 0, 1'b1, "R4 coincident edges no pulse");
        pair(40, -2);
        @(negedge clk); chk(lock_out, 1'b0, "R5 restart after win_len+1");
        // R6: direct lock without mask
        pair(40, 3);
        @(negedge clk); chk(lock_out, 1'b1, "R6 lock follows raw");
        pair(40, -4);
        @(negedge clk); chk(lock_out, 1'b0, "R6 dropout visible");

        // R7: masked lock
        mask_len = 16'd60;
        pair(40, 2); pair(40, 2); pair(40, 2); pair(40, 2);
        @(negedge clk); chk(lock_out, 1'b0, "R7 lock delayed by mask");
        pair(40, 8);
        @(negedge clk); chk(lock_out, 1'b1, "R7 dropout hidden in mask");
        // R8: dropout after mask
        pair(40, -6);
        @(negedge clk); chk(lock_out, 1'b0, "R8 dropout after mask");
        pair(40, 1);
        @(negedge clk); chk(lock_out, 1'b0, "R8 requalify needed");
        chk(sb_q.size() == 0, 1'b1, "R2 R3 all pulses observed");
        sb_on = 1'b0;

        // R10: enable low
        spin(100, 105, 630, 1'b1);
        @(negedge clk); chk(cur_scale, 1'b0, "R10 disabled");
        // R9: near speed
        nearspd_en = 1'b1;
        spin(100, 105, 630, 1'b1);
        @(negedge clk); chk(cur_scale, 1'b1, "R9 period 105 near");
        nearspd_en = 1'b0;
        @(negedge clk);
        @(negedge clk); chk(cur_scale, 1'b0, "R10 enable dropped");
        nearspd_en = 1'b1;
        spin(100, 106, 700, 1'b1);
        @(negedge clk); chk(cur_scale, 1'b0, "R9 period 106 not near");
        spin(100, 105, 630, 1'b1);
        @(negedge clk); chk(cur_scale, 1'b1, "R9 back to near");
        // R11: FG stops
        spin(100, 105, 160, 1'b0);
        @(negedge clk); chk(cur_scale, 1'b0, "R11 stalled FG");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule